// File: doc/BRIEF.md
# Variable-Length Message Receive Ring

This block holds received CAN messages in a 64-byte circular byte store. A receiver engine writes each message as a stream of bytes. A start strobe marks the first byte, and the message ends with either a commit strobe or a discard strobe. A message is visible to the host only after it has been committed. If a byte arrives and the ring has no room for it, the block removes every byte of the message in progress and raises a sticky overrun flag.

The host sees a 13-byte window. The window starts at the first byte of the oldest stored message and wraps around the end of the ring. The host can also read the start address, the number of stored messages and a not-empty flag. A release command drops the oldest message. It moves the start address by that message's length, which the block works out from the message's first (header) byte. A clear command resets the overrun flag.

Top module: `rx_msg_ring`

## Requirements
- R1: After reset, start_addr is 0, msg_cnt is 0, not_empty is 0 and overrun is 0.
- R2: Byte k of the window (win_data[8k+7:8k], k = 0..12) always equals the stored byte at address (start_addr + k) mod 64.
- R3: Bytes of a message are stored at consecutive ring addresses after the last committed byte. A commit makes the message count as stored and increments msg_cnt. At most one of wr_valid, wr_commit and wr_discard is high in a cycle, and wr_sof is valid only together with wr_valid. Committed plus in-progress bytes never exceed 64.
- R4: The header byte fixes the message length. Bit 7 = 1 gives an extended frame with base length 5; bit 7 = 0 gives a standard frame with base length 3. To the base is added the data count: the value of bits 3:0 capped at 8, or 0 when bit 6 is set.
- R5: Release with msg_cnt > 0 advances start_addr by the oldest message's length (mod 64) and decrements msg_cnt. Release with msg_cnt = 0 changes nothing.
- R6: wr_discard, or a new wr_sof before a commit, drops the uncommitted bytes. The next message is written from the same address, and msg_cnt does not change.
- R7: A byte that would make committed plus in-progress bytes exceed 64 is not stored. The in-progress message is deleted and overrun is set. Further bytes and a commit are ignored until the next wr_sof or wr_discard.
- R8: overrun stays set until clr_ovr. When an overrun event and clr_ovr happen in the same cycle, overrun stays set.
- R9: not_empty is 1 exactly when msg_cnt is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_sof | input | 1 | First byte of a new message (with wr_valid) |
| wr_valid | input | 1 | wr_data holds a message byte |
| wr_data | input | 8 | Message byte |
| wr_commit | input | 1 | Keep the message in progress |
| wr_discard | input | 1 | Drop the message in progress |
| rel_cmd | input | 1 | Release the oldest message |
| clr_ovr | input | 1 | Clear overrun |
| win_data | output | 104 | 13-byte window, byte k in bits 8k+7:8k |
| start_addr | output | 6 | Address of the oldest message |
| msg_cnt | output | 5 | Stored message count |
| not_empty | output | 1 | At least one message stored |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The assertions check the following on every cycle:
- the byte-occupancy bound;
- that the committed byte count and the message count are zero together;
- that overrun is sticky;
- that msg_cnt does not move without a commit or a release;
- that a release with no stored messages does nothing;
- that the write strobes are mutually exclusive.

The length rule, the window wrap across address 63, the rollback of a partly written message and the priority of set over clear can only be shown by the bench scenarios. The bench compares every output against a behavioural model on every clock.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int unsigned HDR_EXT_BIT  = 7;
   localparam int unsigned HDR_RTR_BIT  = 6;
   localparam int unsigned STD_BASE_LEN = 3;
   localparam int unsigned EXT_BASE_LEN = 5;
   localparam int unsigned MAX_DATA     = 8;

   // Message length in bytes derived from its header byte
   function automatic logic [3:0] msg_len(input logic [7:0] hdr);
      logic [3:0] data_n;
      if (hdr[HDR_RTR_BIT])
         data_n = 4'd0;
      else if (hdr[3:0] > 4'(MAX_DATA))
         data_n = 4'(MAX_DATA);
      else
         data_n = hdr[3:0];
      return (hdr[HDR_EXT_BIT] ? 4'(EXT_BASE_LEN) : 4'(STD_BASE_LEN)) + data_n;
   endfunction
endpackage

// File: rtl/rxr_store.sv
module rxr_store #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned WIN   = 13,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [7:0]        wdata,
   input  logic [AW-1:0]     base,
   output logic [WIN*8-1:0]  window,
   output logic [7:0]        head
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   for (genvar k = 0; k < WIN; k++) begin : g_win
      logic [AW-1:0] a;
      assign a = base + AW'(k);
      assign window[k*8 +: 8] = mem[a];
   end

   assign head = window[7:0];
endmodule

// File: rtl/rxr_wr_ctrl.sv
module rxr_wr_ctrl #(
   parameter int unsigned DEPTH = 64,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_sof,
   input  logic          wr_valid,
   input  logic          wr_commit,
   input  logic          wr_discard,
   input  logic [CW-1:0] used,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic          commit_fire,
   output logic [CW-1:0] commit_len,
   output logic          ovr_evt
);
   logic [AW-1:0] wr_ptr;
   logic [CW-1:0] tent;
   logic          drop;
   logic [CW-1:0] tent_base;
   logic          drop_eff;
   logic          fits;

   assign tent_base = wr_sof ? '0 : tent;
   assign drop_eff  = wr_sof ? 1'b0 : drop;
   assign fits      = ({1'b0, used} + {1'b0, tent_base}) < (CW+1)'(DEPTH);

   assign we          = wr_valid && !drop_eff && fits;
   assign ovr_evt     = wr_valid && !drop_eff && !fits;
   assign waddr       = wr_ptr + tent_base[AW-1:0];
   assign commit_fire = wr_commit && !drop && (tent != '0);
   assign commit_len  = tent;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         tent   <= '0;
         drop   <= 1'b0;
      end else if (wr_valid) begin
         drop <= drop_eff;
         if (we) begin
            tent <= tent_base + CW'(1);
         end else if (ovr_evt) begin
            tent <= '0;
            drop <= 1'b1;
         end
      end else if (wr_discard) begin
         tent <= '0;
         drop <= 1'b0;
      end else if (commit_fire) begin
         wr_ptr <= wr_ptr + tent[AW-1:0];
         tent   <= '0;
      end
   end

   // R3: committed plus in-progress bytes stay within the ring
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, used} + {1'b0, tent}) <= (CW+1)'(DEPTH));
   // R3: write strobes are mutually exclusive; sof only with a byte
   a_r3_strobes_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_valid, wr_commit, wr_discard}) && (!wr_sof || wr_valid));
endmodule

// File: rtl/rx_msg_ring.sv
module rx_msg_ring #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned WIN   = 13,
   parameter int unsigned CNT_W = 5,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_sof,
   input  logic             wr_valid,
   input  logic [7:0]       wr_data,
   input  logic             wr_commit,
   input  logic             wr_discard,
   input  logic             rel_cmd,
   input  logic             clr_ovr,
   output logic [WIN*8-1:0] win_data,
   output logic [AW-1:0]    start_addr,
   output logic [CNT_W-1:0] msg_cnt,
   output logic             not_empty,
   output logic             overrun
);
   import rxr_pkg::*;

   if ((1 << AW) != DEPTH) begin : g_chk_pow2
      $error("DEPTH must be a power of two");
   end
   if (DEPTH < 16 || WIN > DEPTH) begin : g_chk_win
      $error("DEPTH must be at least 16 and hold the window");
   end
   if ((1 << CNT_W) <= DEPTH / STD_BASE_LEN) begin : g_chk_cnt
      $error("CNT_W too narrow for the message count");
   end

   logic [CW-1:0] used;
   logic          we;
   logic [AW-1:0] waddr;
   logic          commit_fire;
   logic [CW-1:0] commit_len;
   logic          ovr_evt;
   logic [7:0]    head;
   logic          rel_fire;
   logic [3:0]    rel_len;

   rxr_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .clk(clk), .rst_n(rst_n), .wr_sof(wr_sof), .wr_valid(wr_valid),
      .wr_commit(wr_commit), .wr_discard(wr_discard), .used(used),
      .we(we), .waddr(waddr), .commit_fire(commit_fire),
      .commit_len(commit_len), .ovr_evt(ovr_evt)
   );

   rxr_store #(.DEPTH(DEPTH), .WIN(WIN)) u_store (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wr_data),
      .base(start_addr), .window(win_data), .head(head)
   );

   assign rel_fire = rel_cmd && (msg_cnt != '0);
   assign rel_len  = msg_len(head);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_addr <= '0;
         used       <= '0;
         msg_cnt    <= '0;
         overrun    <= 1'b0;
      end else begin
         used <= used + (commit_fire ? commit_len : '0)
                      - (rel_fire ? CW'(rel_len) : '0);
         if (rel_fire) start_addr <= start_addr + AW'(rel_len);
         if (commit_fire && !rel_fire)      msg_cnt <= msg_cnt + CNT_W'(1);
         else if (rel_fire && !commit_fire) msg_cnt <= msg_cnt - CNT_W'(1);
         if (ovr_evt)      overrun <= 1'b1;
         else if (clr_ovr) overrun <= 1'b0;
      end
   end

   assign not_empty = (msg_cnt != '0);

   // R9: message count and committed byte count are empty together
   a_r9_empty_matches_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_cnt == '0) == (used == '0));
   // R8: overrun is sticky until cleared
   a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && !clr_ovr |=> overrun);
   // R5: release on an empty ring leaves the start address alone
   a_r5_rel_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
      rel_cmd && (msg_cnt == '0) |=> $stable(start_addr));
   // R3: count moves only on commit or release
   a_r3_cnt_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_commit && !rel_cmd |=> $stable(msg_cnt));
endmodule

// File: tb/tb_rx_msg_ring.sv
module tb_rx_msg_ring;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_sof = 0, wr_valid = 0, wr_commit = 0, wr_discard = 0;
   logic         rel_cmd = 0, clr_ovr = 0;
   logic [7:0]   wr_data = 0;
   logic [103:0] win_data;
   logic [5:0]   start_addr;
   logic [4:0]   msg_cnt;
   logic         not_empty, overrun;

   int errors = 0, checks = 0, cycles = 0;
   bit done = 0;

   // behavioural reference model
   int m_mem [64];
   int m_rd = 0, m_wr = 0, m_used = 0, m_tent = 0, m_cnt = 0;
   bit m_ovr = 0, m_drop = 0;

   always #5 clk = ~clk;

   rx_msg_ring dut (
      .clk(clk), .rst_n(rst_n), .wr_sof(wr_sof), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_commit(wr_commit), .wr_discard(wr_discard),
      .rel_cmd(rel_cmd), .clr_ovr(clr_ovr), .win_data(win_data),
      .start_addr(start_addr), .msg_cnt(msg_cnt), .not_empty(not_empty),
      .overrun(overrun)
   );

   function automatic int ref_len(int h);
      int d;
      d = ((h >> 6) & 1) ? 0 : (((h & 15) > 8) ? 8 : (h & 15));
      return (((h >> 7) & 1) ? 5 : 3) + d;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_mem[i]) m_mem[i] = 0;
         m_rd = 0; m_wr = 0; m_used = 0; m_tent = 0; m_cnt = 0;
         m_ovr = 0; m_drop = 0;
      end else begin
         int old_cnt, old_used, rl;
         bit set_ovr;
         old_cnt = m_cnt; old_used = m_used; set_ovr = 0;
         if (wr_sof) begin m_tent = 0; m_drop = 0; end
         if (wr_valid && !m_drop) begin
            if (old_used + m_tent < 64) begin
               m_mem[(m_wr + m_tent) % 64] = wr_data;
               m_tent++;
            end else begin
               set_ovr = 1; m_tent = 0; m_drop = 1;
            end
         end
         if (wr_discard) begin m_tent = 0; m_drop = 0; end
         if (rel_cmd && old_cnt > 0) begin
            rl = ref_len(m_mem[m_rd]);
            m_rd = (m_rd + rl) % 64;
            m_used -= rl;
            m_cnt--;
         end
         if (wr_commit && !m_drop && m_tent > 0) begin
            m_wr = (m_wr + m_tent) % 64;
            m_used += m_tent;
            m_tent = 0;
            m_cnt++;
         end
         if (set_ovr) m_ovr = 1;
         else if (clr_ovr) m_ovr = 0;
      end
   end

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int k = 0; k < 13; k++)
            chk($sformatf("R2 window byte %0d", k), int'(win_data[k*8 +: 8]),
                m_mem[(m_rd + k) % 64]);
         chk("R5 start_addr", int'(start_addr), m_rd);
         chk("R3 msg_cnt", int'(msg_cnt), m_cnt);
         chk("R9 not_empty", int'(not_empty), (m_cnt != 0) ? 1 : 0);
         chk("R7 overrun", int'(overrun), int'(m_ovr));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // n bytes, header first; optional commit; optional clear on the last byte
   task automatic send(input logic [7:0] hdr, input int n, input bit do_commit,
                       input bit clr_last);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_valid = 1;
         wr_sof   = (i == 0);
         wr_data  = (i == 0) ? hdr : 8'(8'h30 + i + hdr);
         clr_ovr  = clr_last && (i == n - 1);
      end
      @(negedge clk);
      wr_valid = 0; wr_sof = 0; clr_ovr = 0;
      wr_commit = do_commit;
      @(negedge clk);
      wr_commit = 0;
   endtask

   task automatic release_one();
      @(negedge clk); rel_cmd = 1;
      @(negedge clk); rel_cmd = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 reset start", int'(start_addr), 0);
      chk("R1 reset cnt", int'(msg_cnt), 0);
      chk("R1 reset not_empty", int'(not_empty), 0);
      chk("R1 reset overrun", int'(overrun), 0);

      // R4 length variants
      send(8'h02, 5, 1, 0);   // std, 2 data -> 5
      send(8'h88, 13, 1, 0);  // ext, 8 data -> 13
      send(8'h45, 3, 1, 0);   // std rtr -> 3
      send(8'h0F, 11, 1, 0);  // std, dlc 15 capped -> 11
      send(8'hCF, 5, 1, 0);   // ext rtr -> 5
      chk("R3 count after five commits", int'(msg_cnt), 5);
      release_one(); chk("R4 std len 5", int'(start_addr), 5);
      release_one(); chk("R4 ext len 13", int'(start_addr), 18);
      release_one(); chk("R4 rtr len 3", int'(start_addr), 21);
      release_one(); chk("R4 capped len 11", int'(start_addr), 32);
      release_one(); chk("R4 ext rtr len 5", int'(start_addr), 37);
      chk("R5 count after releases", int'(msg_cnt), 0);

      // R6 discard then reuse
      send(8'h08, 4, 0, 0);
      @(negedge clk); wr_discard = 1;
      @(negedge clk); wr_discard = 0;
      chk("R6 count after discard", int'(msg_cnt), 0);
      send(8'h01, 4, 1, 0);
      chk("R6 header at reused address", int'(win_data[7:0]), 8'h01);
      chk("R6 count", int'(msg_cnt), 1);
      release_one();
      chk("R5 start after release", int'(start_addr), 41);

      // R7 overrun with wrap past address 63
      for (int j = 0; j < 4; j++) send(8'h88, 13, 1, 0);
      send(8'h88, 13, 1, 0);
      chk("R7 overrun set", int'(overrun), 1);
      chk("R7 partial message dropped", int'(msg_cnt), 4);
      // R8 set wins over clear in the same cycle
      send(8'h88, 13, 1, 1);
      chk("R8 set beats clear", int'(overrun), 1);
      @(negedge clk); clr_ovr = 1;
      @(negedge clk); clr_ovr = 0;
      chk("R8 cleared", int'(overrun), 0);
      send(8'h00, 3, 1, 0);
      chk("R3 fits after rollback", int'(msg_cnt), 5);

      for (int j = 0; j < 5; j++) release_one();
      chk("R5 start after drain", int'(start_addr), 32);
      release_one();
      chk("R5 empty release ignored", int'(start_addr), 32);
      chk("R9 empty", int'(not_empty), 0);

      repeat (2) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule